// File: doc/BRIEF.md
# Lane-Parallel Integer Sum Reducer

This block adds up a stream of W-bit integers. It does not use one serial accumulator. It keeps VL partial sums, one per lane. Each accepted input beat carries a chunk of up to VL elements together with a count. The block adds lane i of the chunk into partial sum i, but only for the lanes below the count. By convention, a producer sends the N mod VL leftover elements in the first beat and full chunks after that, and it flags the final beat with a last bit.

Once the final beat has been absorbed, the block stops taking input and folds the partial sums. Each cycle it halves the active length and adds the upper half of the lanes into the lower half. After log2(VL) folding cycles one value remains. That value is shown on the result port for one cycle. The partial sums then return to zero and input is accepted again. All sums wrap modulo 2^W, so the lane-parallel grouping gives exactly the value a serial loop would.

Top module: `vsum_reducer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every partial sum is zero, so a reduction whose only beat has in_cnt = 0 yields 0.
- R2: A beat is taken only on a rising edge where in_valid and in_ready are both 1. Data presented with in_valid low, or while in_ready is low, has no effect on any result.
- R3: Element i of a beat occupies in_data bits [i*W +: W]. It is added only when i < in_cnt. An in_cnt of 0 adds nothing, and any in_cnt of VL or more adds all lanes.
- R4: out_sum equals the sum of every added element of the reduction, with the upper-half-into-lower-half folding giving the same total as a serial sum.
- R5: out_valid rises exactly log2(VL) = 3 cycles after the edge that accepted the beat with in_last = 1, and it stays high for exactly one cycle.
- R6: in_ready is 0 from the edge that accepts the last beat through the cycle in which out_valid is 1, and it is 1 again in the following cycle.
- R7: The partial sums are cleared when the result has been shown, so each reduction starts from zero.
- R8: Sums wrap modulo 2^W, for example eight elements of 2^W-1 give 2^W-8.
- R9: A reduction sent as a short remainder beat followed by full beats gives the serial sum of its N elements for any N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_last | input | 1 | Beat is the final chunk of the reduction |
| in_cnt | input | $clog2(VL+1) | Number of leading lanes that hold elements |
| in_data | input | VL*W | Chunk, lane i in bits [i*W +: W] |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | W | Reduced total, valid with out_valid |

## Verification
The bench drives and samples on the falling edge. When it sees in_ready high there, the beat it drives is taken at the next rising edge. Counting from the falling edge just after the last beat is accepted, the bench expects out_valid low and in_ready low at the first three falling edges, and the result at the fourth, one falling edge after each of the three folding edges. At the fifth falling edge it expects out_valid low and in_ready high. During the folding cycles the bench holds garbage on the input with in_valid high. Any later result then shows whether that data was wrongly taken.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_FOLD   = 2'd1,
    ST_SHOW   = 2'd2
  } vsr_state_e;

endpackage

// File: rtl/vsr_mask.sv
module vsr_mask #(
  parameter int W    = 16,
  parameter int VL   = 8,
  parameter int CNTW = 4
) (
  input  logic [VL*W-1:0] chunk,
  input  logic [CNTW-1:0] cnt,
  output logic [VL*W-1:0] masked
);

  function automatic logic lane_on(input int idx, input logic [CNTW-1:0] c);
    return idx < int'(c);
  endfunction

  for (genvar i = 0; i < VL; i++) begin : g_lane
    assign masked[i*W +: W] = lane_on(i, cnt) ? chunk[i*W +: W] : '0;
  end

endmodule

// File: rtl/vsr_lanes.sv
module vsr_lanes #(
  parameter int W    = 16,
  parameter int VL   = 8,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            acc_en,
  input  logic [VL*W-1:0] add_vec,
  input  logic            fold_en,
  input  logic [LENW-1:0] half,
  output logic [W-1:0]    lane0
);

  logic [VL*W-1:0] psum_flat;

  function automatic logic [W-1:0] wadd(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [W-1:0] get_lane(input logic [VL*W-1:0] v, input int p);
    return (p < VL) ? v[p*W +: W] : '0;
  endfunction

  for (genvar i = 0; i < VL; i++) begin : g_lane
    logic [W-1:0] acc_q;
    logic [W-1:0] partner;

    assign partner = get_lane(psum_flat, i + int'(half));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (clr) begin
        acc_q <= '0;
      end else if (acc_en) begin
        acc_q <= wadd(acc_q, add_vec[i*W +: W]);
      end else if (fold_en) begin
        if (LENW'(i) < half) acc_q <= wadd(acc_q, partner);
        else                 acc_q <= '0;
      end
    end

    assign psum_flat[i*W +: W] = acc_q;
  end

  assign lane0 = psum_flat[W-1:0];

  AST_ACC_FOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && fold_en)); // R4
  AST_FOLD_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |-> ($countones(half) == 1)); // R4
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (psum_flat == '0)); // R7

endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int VL   = 8,
  parameter int LENW = 4,
  parameter int LOG2 = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  output logic            in_ready,
  output logic            acc_en,
  output logic            clr,
  output logic            fold_en,
  output logic [LENW-1:0] half,
  output logic            out_valid
);

  vsr_state_e      state_q;
  logic [LENW-1:0] len_q;
  logic [LENW-1:0] since_last_q;
  logic            last_take;

  assign in_ready  = (state_q == ST_GATHER);
  assign acc_en    = in_valid && in_ready;
  assign last_take = acc_en && in_last;
  assign fold_en   = (state_q == ST_FOLD);
  assign half      = len_q >> 1;
  assign out_valid = (state_q == ST_SHOW);
  assign clr       = out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_GATHER: begin
          if (last_take) begin
            state_q <= ST_FOLD;
            len_q   <= LENW'(VL);
          end
        end
        ST_FOLD: begin
          len_q <= half;
          if (half == LENW'(1)) state_q <= ST_SHOW;
        end
        ST_SHOW: state_q <= ST_GATHER;
        default: state_q <= ST_GATHER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        since_last_q <= '0;
    else if (last_take) since_last_q <= '0;
    else if (fold_en)   since_last_q <= since_last_q + LENW'(1);
  end

  AST_RESULT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_last_q == LENW'(LOG2))); // R5
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !in_ready); // R6
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready); // R6

endmodule

// File: rtl/vsum_reducer.sv
module vsum_reducer #(
  parameter int W  = 16,
  parameter int VL = 8,
  localparam int CNTW = $clog2(VL + 1),
  localparam int LENW = $clog2(VL) + 1,
  localparam int LOG2 = $clog2(VL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_last,
  input  logic [CNTW-1:0] in_cnt,
  input  logic [VL*W-1:0] in_data,
  output logic            out_valid,
  output logic [W-1:0]    out_sum
);

  logic [VL*W-1:0] masked;
  logic            acc_en;
  logic            clr;
  logic            fold_en;
  logic [LENW-1:0] half;
  logic [W-1:0]    lane0;

  vsr_mask #(.W(W), .VL(VL), .CNTW(CNTW)) u_mask (
    .chunk  (in_data),
    .cnt    (in_cnt),
    .masked (masked)
  );

  vsr_ctrl #(.VL(VL), .LENW(LENW), .LOG2(LOG2)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .acc_en    (acc_en),
    .clr       (clr),
    .fold_en   (fold_en),
    .half      (half),
    .out_valid (out_valid)
  );

  vsr_lanes #(.W(W), .VL(VL), .LENW(LENW)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .acc_en  (acc_en),
    .add_vec (masked),
    .fold_en (fold_en),
    .half    (half),
    .lane0   (lane0)
  );

  assign out_sum = out_valid ? lane0 : '0;

  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2

endmodule

// File: tb/vsum_reducer_bench.sv
`timescale 1ns/1ps
module vsum_reducer_bench;

  localparam int W    = 16;
  localparam int VL   = 8;
  localparam int CNTW = $clog2(VL + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic            in_last;
  logic [CNTW-1:0] in_cnt;
  logic [VL*W-1:0] in_data;
  logic            out_valid;
  logic [W-1:0]    out_sum;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_sum;

  always #2 clk = ~clk;

  vsum_reducer #(.W(W), .VL(VL)) u_vsum_reducer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .in_cnt    (in_cnt),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  function automatic logic [VL*W-1:0] rand_vec();
    logic [VL*W-1:0] v;
    for (int i = 0; i < VL; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  function automatic logic [W-1:0] beat_total(input logic [VL*W-1:0] d, input int c);
    logic [W-1:0] s = '0;
    int k = 0;
    while (k < c && k < VL) begin
      s = s + d[k*W +: W];
      k++;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int g = 0; g < n; g++) begin
      in_valid = 1'b0;
      in_data  = rand_vec();
      in_cnt   = CNTW'($urandom_range(0, VL));
      in_last  = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_beat(input logic [VL*W-1:0] d, input int c, input bit last);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_cnt   = CNTW'(c);
    in_last  = last;
    exp_sum  = exp_sum + beat_total(d, c);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic expect_result(input string tag);
    for (int j = 0; j < 3; j++) begin
      check(!out_valid && !in_ready, "R5/R6 folding window", {out_valid, in_ready}, 0);
      in_valid = 1'b1;
      in_last  = 1'b1;
      in_cnt   = CNTW'(VL);
      in_data  = rand_vec();
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(out_valid == 1'b1, "R5 result strobe", out_valid, 1);
    check(out_sum == exp_sum, tag, out_sum, exp_sum);
    check(in_ready == 1'b0, "R6 ready low with result", in_ready, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 single-cycle strobe", out_valid, 0);
    check(in_ready == 1'b1, "R6 ready back", in_ready, 1);
  endtask

  task automatic run_reduction(input int n, input bit all_ones, input bit gaps);
    int left;
    int c;
    logic [VL*W-1:0] d;
    exp_sum = '0;
    if (n == 0) begin
      send_beat(rand_vec(), 0, 1'b1);
    end else begin
      left = n;
      c = (n % VL != 0) ? n % VL : VL;
      while (left > 0) begin
        d = all_ones ? '1 : rand_vec();
        if (gaps) idle_gap($urandom_range(0, 2));
        send_beat(d, c, left == c);
        left -= c;
        c = VL;
      end
    end
    expect_result(all_ones ? "R8 wrap total" : "R4/R9 strip-mined total");
  endtask

  initial begin
    #(4ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_cnt   = '0;
    in_data  = '0;
    exp_sum  = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 idle out_valid", out_valid, 0);

    // R1: fresh sums, empty reduction yields zero
    exp_sum = '0;
    send_beat(rand_vec(), 0, 1'b1);
    expect_result("R1 zero start");

    // R3: count above VL adds all lanes; count 0 beat in middle adds nothing
    exp_sum = '0;
    send_beat(rand_vec(), 15, 1'b0);
    send_beat(rand_vec(), 0, 1'b0);
    send_beat(rand_vec(), 3, 1'b1);
    expect_result("R3 lane masking");

    // R8: wrap with all-ones elements
    run_reduction(8, 1'b1, 1'b0);
    run_reduction(21, 1'b1, 1'b1);

    // R9 directed lengths: exact multiple, one element, remainder VL-1
    run_reduction(16, 1'b0, 1'b0);
    run_reduction(1, 1'b0, 1'b0);
    run_reduction(7, 1'b0, 1'b1);

    // R2: garbage held with valid low in gather state before a reduction
    idle_gap(4);
    run_reduction(13, 1'b0, 1'b1);

    // R7: after a nonzero reduction the next empty one gives zero
    run_reduction(0, 1'b0, 1'b0);

    for (int r = 0; r < 25; r++) begin
      run_reduction($urandom_range(0, 45), 1'b0, 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule